// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block steps a processor core through its clock-throttled power-saving states. A stop-clock request moves the core out of normal running. When the extended-state enable is clear, the core goes to a plain stop-grant state. When the enable is set, it goes to an extended stop-grant state, which runs at a reduced bus ratio and a reduced voltage ID.

Power-down is sequenced so that the bus ratio drops first and the voltage ID second. Power-up runs the other way: the voltage is restored while the clock ratio stays low, and only then is the ratio raised. Each step is a state of its own and lasts a parameterised number of settle cycles.

Snoops that arrive in either stop state are held in a snoop sub-state until they have been serviced, and the controller then returns to the stop state it came from. From either stop state a sleep request gates all internal clocks and disables snoop response. A sleep request made in any other state is a protocol violation and is recorded in a sticky flag.

Top module: `lpstate_ctrl`

## Requirements
- R1: state_code encoding: 0 running, 1 stop-grant, 2 stop-grant snoop, 3 entry ratio step, 4 entry voltage step, 5 extended stop-grant, 6 extended snoop, 7 exit voltage step, 8 exit ratio step, 9 sleep from stop-grant, 10 sleep from extended. In running, a stop_req high at a clock edge moves the state to 3 when ext_en is 1, and to 1 when ext_en is 0.
- R2: On entry, ratio_low goes high in state 3 while vid_low stays low. After SETTLE cycles the state becomes 4 and vid_low goes high. After a further SETTLE cycles the state becomes 5.
- R3: In state 5, brk_evt high or stop_req low starts the exit sequence. vid_low drops in state 7 while ratio_low stays high. After SETTLE cycles ratio_low drops in state 8, and after a further SETTLE cycles the state is 0.
- R4: In state 1, the conditions are tested in this priority: first brk_evt high or stop_req low (go to 0), then snoop_req (go to 2), then sleep_req (go to 9). State 2 holds until snoop_done is seen, and then returns to 1.
- R5: In state 5, snoop_req moves the state to 6 when no exit condition is present. State 6 keeps ratio_low and vid_low high, holds until snoop_done, and then returns to 5.
- R6: sleep_req in state 1 enters state 9, and in state 5 enters state 10. In a sleep state clk_en and snoop_en are 0, and ratio_low and vid_low keep their stop-state values. Dropping sleep_req returns the state to 1 or 5 respectively.
- R7: sleep_req high at a clock edge in any state other than 1, 5, 9 or 10 sets proto_err, which stays set until reset. The sleep request causes no state change.
- R8: After reset the state is 0, ratio_low and vid_low are 0, clk_en and snoop_en are 1, and proto_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | Stop-clock request, level |
| sleep_req | input | 1 | Sleep request, level |
| snoop_req | input | 1 | Snoop pending |
| snoop_done | input | 1 | Snoop serviced by this agent or another |
| brk_evt | input | 1 | Break event |
| ext_en | input | 1 | Enable for the extended stop state |
| ratio_low | output | 1 | Bus ratio select, 1 = low ratio |
| vid_low | output | 1 | Voltage ID select, 1 = low voltage |
| clk_en | output | 1 | Internal clock enable |
| snoop_en | output | 1 | Snoop response enable |
| state_code | output | 4 | Current state code |
| proto_err | output | 1 | Sticky sleep protocol error |

## Verification
The hardest situations to reach from the ports are the ones where several inputs compete in a single cycle. Examples are a snoop and a break arriving together in a stop state, and a sleep request made during a settle step of the entry or exit sequence. Directed sequences first walk both the plain path and the extended path. A seeded random phase then holds stop_req mostly high and toggles snoop, sleep, break and ext_en at independent rates, so these collisions and mid-sequence sleep requests occur many times. A cycle-accurate bench model predicts every output on every cycle.

// File: rtl/lpstate_pkg.sv
// Package: shared state encoding for the low-power state controller.
// Assumes: codes are externally visible through state_code and must stay fixed.
package lpstate_pkg;
    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_RUN       = 4'd0,
        ST_SG        = 4'd1,
        ST_SG_SNP    = 4'd2,
        ST_ENT_RATIO = 4'd3,
        ST_ENT_VID   = 4'd4,
        ST_ESG       = 4'd5,
        ST_ESG_SNP   = 4'd6,
        ST_EXT_VID   = 4'd7,
        ST_EXT_RATIO = 4'd8,
        ST_SLP_SG    = 4'd9,
        ST_SLP_ESG   = 4'd10
    } lp_state_e;
endpackage

// File: rtl/lpstate_settle_timer.sv
// Module: settle timer shared by all ratio and voltage steps.
// Each step state lasts exactly SETTLE cycles. The count restarts on every state change.
// Assumes: SETTLE >= 1, and restart is high in the cycle that leads into a new state.
module lpstate_settle_timer #(
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic restart,
    output logic done
);
    localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles spent in the current step state; clear on reset or state change.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (active && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Step complete on the last settle cycle.
    assign done = active && (cnt_q == LAST);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/lpstate_seq.sv
// Module: sequencing state machine and sticky protocol-error flag.
// Assumes: step_done comes from the settle timer and refers to the current state.
// Exit conditions take priority over snoops, and snoops take priority over sleep.
module lpstate_seq
    import lpstate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_req,
    input  logic      sleep_req,
    input  logic      snoop_req,
    input  logic      snoop_done,
    input  logic      brk_evt,
    input  logic      ext_en,
    input  logic      step_done,
    output lp_state_e state_q,
    output logic      step_active,
    output logic      restart,
    output logic      proto_err
);
    lp_state_e state_d;
    logic      leave_stop;
    logic      sleep_ok;
    logic      err_q;

    assign leave_stop = brk_evt || !stop_req;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:       if (stop_req) state_d = ext_en ? ST_ENT_RATIO : ST_SG;
            ST_SG: begin
                if (leave_stop)     state_d = ST_RUN;
                else if (snoop_req) state_d = ST_SG_SNP;
                else if (sleep_req) state_d = ST_SLP_SG;
            end
            ST_SG_SNP:    if (snoop_done) state_d = ST_SG;
            ST_ENT_RATIO: if (step_done) state_d = ST_ENT_VID;
            ST_ENT_VID:   if (step_done) state_d = ST_ESG;
            ST_ESG: begin
                if (leave_stop)     state_d = ST_EXT_VID;
                else if (snoop_req) state_d = ST_ESG_SNP;
                else if (sleep_req) state_d = ST_SLP_ESG;
            end
            ST_ESG_SNP:   if (snoop_done) state_d = ST_ESG;
            ST_EXT_VID:   if (step_done) state_d = ST_EXT_RATIO;
            ST_EXT_RATIO: if (step_done) state_d = ST_RUN;
            ST_SLP_SG:    if (!sleep_req) state_d = ST_SG;
            ST_SLP_ESG:   if (!sleep_req) state_d = ST_ESG;
            default:      state_d = ST_RUN;
        endcase
    end

    // Timer control: which states are settle steps, and when the count restarts.
    always_comb begin
        step_active = (state_q == ST_ENT_RATIO) || (state_q == ST_ENT_VID) ||
                      (state_q == ST_EXT_VID)   || (state_q == ST_EXT_RATIO);
        restart     = (state_d != state_q);
        sleep_ok    = (state_q == ST_SG) || (state_q == ST_ESG) ||
                      (state_q == ST_SLP_SG) || (state_q == ST_SLP_ESG);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Sticky flag for a sleep request outside the stop states.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q || (sleep_req && !sleep_ok);
    end

    assign proto_err = err_q;

    // R6
    sleep_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SLP_SG) && !$past(state_q == ST_SLP_SG)) |-> $past(state_q == ST_SG));

    // R4
    sg_snoop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SG_SNP && !snoop_done) |=> (state_q == ST_SG_SNP));

    // R5
    esg_snoop_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ESG_SNP && snoop_done) |=> (state_q == ST_ESG));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R7
    run_sleep_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_req && !stop_req) |=> (state_q == ST_RUN && proto_err));
endmodule

// File: rtl/lpstate_outmap.sv
// Module: decodes the current state into the operating-point and enable outputs.
// Assumes: outputs follow the registered state, so they are glitch-free relative to clk.
module lpstate_outmap
    import lpstate_pkg::*;
(
    input  lp_state_e          state_q,
    output logic               ratio_low,
    output logic               vid_low,
    output logic               clk_en,
    output logic               snoop_en,
    output logic [STATE_W-1:0] state_code
);
    // Per-state operating point and enables.
    always_comb begin
        ratio_low = 1'b0;
        vid_low   = 1'b0;
        clk_en    = 1'b1;
        snoop_en  = 1'b1;
        unique case (state_q)
            ST_ENT_RATIO, ST_EXT_VID: ratio_low = 1'b1;
            ST_ENT_VID, ST_ESG, ST_ESG_SNP: begin
                ratio_low = 1'b1;
                vid_low   = 1'b1;
            end
            ST_SLP_SG: begin
                clk_en   = 1'b0;
                snoop_en = 1'b0;
            end
            ST_SLP_ESG: begin
                ratio_low = 1'b1;
                vid_low   = 1'b1;
                clk_en    = 1'b0;
                snoop_en  = 1'b0;
            end
            default: ;
        endcase
        state_code = state_q;
    end
endmodule

// File: rtl/lpstate_ctrl.sv
// Module: top of the low-power state controller.
// Sequences stop-grant, extended stop-grant, the snoop sub-states and sleep.
// Assumes: all inputs are synchronous to clk; SETTLE is the cycle count per operating-point step.
module lpstate_ctrl #(
    parameter int SETTLE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       sleep_req,
    input  logic       snoop_req,
    input  logic       snoop_done,
    input  logic       brk_evt,
    input  logic       ext_en,
    output logic       ratio_low,
    output logic       vid_low,
    output logic       clk_en,
    output logic       snoop_en,
    output logic [3:0] state_code,
    output logic       proto_err
);
    import lpstate_pkg::*;

    lp_state_e state_q;
    logic      step_active;
    logic      restart;
    logic      step_done;

    lpstate_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req   (stop_req),
        .sleep_req  (sleep_req),
        .snoop_req  (snoop_req),
        .snoop_done (snoop_done),
        .brk_evt    (brk_evt),
        .ext_en     (ext_en),
        .step_done  (step_done),
        .state_q    (state_q),
        .step_active(step_active),
        .restart    (restart),
        .proto_err  (proto_err)
    );

    lpstate_settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (step_active),
        .restart(restart),
        .done   (step_done)
    );

    lpstate_outmap u_map (
        .state_q   (state_q),
        .ratio_low (ratio_low),
        .vid_low   (vid_low),
        .clk_en    (clk_en),
        .snoop_en  (snoop_en),
        .state_code(state_code)
    );

    // R2
    vid_after_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_low) |-> (ratio_low && $past(ratio_low)));

    // R3
    ratio_after_vid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ratio_low) |-> (!vid_low && $past(!vid_low)));

    // R6
    sleep_no_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> !snoop_en);
endmodule

// File: tb/lpstate_ctrl_tb.sv
module lpstate_ctrl_tb;
    localparam int S = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, sleep_req = 0, snoop_req = 0, snoop_done = 0, brk_evt = 0, ext_en = 0;
    logic ratio_low, vid_low, clk_en, snoop_en, proto_err;
    logic [3:0] state_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int m_st = 0;
    int m_cnt = 0;
    logic m_err = 1'b0;

    always #2 clk = ~clk;

    lpstate_ctrl #(.SETTLE(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .sleep_req(sleep_req),
        .snoop_req(snoop_req), .snoop_done(snoop_done), .brk_evt(brk_evt), .ext_en(ext_en),
        .ratio_low(ratio_low), .vid_low(vid_low), .clk_en(clk_en), .snoop_en(snoop_en),
        .state_code(state_code), .proto_err(proto_err)
    );

    // Reference model of the requirements, advanced at each rising edge.
    always @(posedge clk) begin
        int nst;
        nst = m_st;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_err = 1'b0;
        end else begin
            if (sleep_req && !(m_st == 1 || m_st == 5 || m_st == 9 || m_st == 10)) m_err = 1'b1;
            case (m_st)
                0: if (stop_req) nst = ext_en ? 3 : 1;
                1: if (brk_evt || !stop_req) nst = 0; else if (snoop_req) nst = 2; else if (sleep_req) nst = 9;
                2: if (snoop_done) nst = 1;
                5: if (brk_evt || !stop_req) nst = 7; else if (snoop_req) nst = 6; else if (sleep_req) nst = 10;
                6: if (snoop_done) nst = 5;
                9: if (!sleep_req) nst = 1;
                10: if (!sleep_req) nst = 5;
                3, 4, 7, 8: begin
                    if (m_cnt == S - 1) nst = (m_st == 3) ? 4 : (m_st == 4) ? 5 : (m_st == 7) ? 8 : 0;
                    else m_cnt = m_cnt + 1;
                end
                default: nst = 0;
            endcase
            if (nst != m_st) m_cnt = 0;
            m_st = nst;
        end
    end

    function automatic string tag_of(int st, logic in_rst);
        if (in_rst) return "R8";
        case (st)
            0: return "R1";
            1, 2: return "R4";
            3, 4: return "R2";
            5, 6: return "R5";
            7, 8: return "R3";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [3:0] exp_outs(int st);
        // {ratio_low, vid_low, clk_en, snoop_en}
        case (st)
            3, 7: return 4'b1011;
            4, 5, 6: return 4'b1111;
            9: return 4'b0000;
            10: return 4'b1100;
            default: return 4'b0011;
        endcase
    endfunction

    task automatic chk(logic ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Compare all outputs against the model; called at the falling edge.
    task automatic compare(logic in_rst);
        string t;
        logic [3:0] e;
        t = tag_of(m_st, in_rst);
        e = exp_outs(m_st);
        chk(state_code == 4'(m_st), t, "state_code", int'(state_code), m_st);
        chk({ratio_low, vid_low, clk_en, snoop_en} == e, t, "outs{ratio,vid,clk,snp}",
            int'({ratio_low, vid_low, clk_en, snoop_en}), int'(e));
        chk(proto_err == m_err, in_rst ? "R8" : "R7", "proto_err", int'(proto_err), int'(m_err));
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare(1'b0);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_up();
        end
    end

    initial begin
        int seed;
        seed = $urandom(20240611);
        // R8 reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            compare(1'b1);
        end
        rst_n = 1'b1;
        run(2);

        // R1 / R4: plain stop-grant, snoop hold, sleep and exit
        ext_en = 0; stop_req = 1; run(3);
        snoop_req = 1; run(2);
        snoop_req = 0; run(3);
        snoop_done = 1; run(1);
        snoop_done = 0; run(2);
        sleep_req = 1; run(3);           // R6 sleep from stop-grant
        sleep_req = 0; run(2);
        snoop_req = 1; sleep_req = 1; brk_evt = 1; run(1);  // R4 priority: exit wins
        snoop_req = 0; sleep_req = 0; brk_evt = 0; stop_req = 0; run(2);

        // R2 / R5 / R3: extended path
        ext_en = 1; stop_req = 1; run(2 * S + 3);
        snoop_req = 1; run(1);
        snoop_req = 0; run(3);
        snoop_done = 1; run(1);
        snoop_done = 0; run(1);
        sleep_req = 1; run(3);           // R6 sleep from extended
        sleep_req = 0; run(2);
        brk_evt = 1; run(1);
        brk_evt = 0; run(2);
        sleep_req = 1; run(1);           // R7 sleep during exit step
        sleep_req = 0; run(2 * S + 2);
        stop_req = 0; run(2);

        // R7 sleep while running
        sleep_req = 1; run(2);
        sleep_req = 0; run(2);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            stop_req   = ($urandom % 100) < 92;
            snoop_req  = ($urandom % 100) < 20;
            snoop_done = ($urandom % 100) < 30;
            brk_evt    = ($urandom % 100) < 4;
            sleep_req  = ($urandom % 100) < 15;
            if (($urandom % 100) < 3) ext_en = ~ext_en;
            run(1);
        end
        finish_up();
    end
endmodule